// File: doc/BRIEF.md
# Parallel-Port Drive Bridge Decoder

This block sits on the device side of a PC parallel port and turns host port activity into accesses to a small drive-style register model. The host supplies an 8-bit data byte and an 8-bit control value (the logical value it wrote, with no pin inversions). The block returns an 8-bit status byte, and during burst reads it drives a byte back onto the data lines. Both host inputs are first brought into the block's clock domain through a synchronizer chain. Every change of the synchronized control value counts as one step.

An access starts with a fixed control waveform that captures the data byte as an access address. Bits [4:3] of that address choose a register bank, bits [2:0] choose the register, and bits [7:6] = 11 choose byte-wide burst reading. The byte 0x20 deselects the adapter.

Once an address is held, the host can do any of three things. It can read the register one nibble at a time on the upper status bits. It can write the register with a strobe pulse. It can stream bytes out by toggling the control value. Register 0 of the task bank is a data port backed by a byte FIFO: writes fill the FIFO and burst reads drain it.

Top module: `ppide_bridge`

## Requirements
- R1: After reset the adapter is deselected, statusOut is 0x00, dataOe is low and the data FIFO is empty.
- R2: An address is captured from the data lines only when the control value steps through 0x0C, 0x0E, 0x0E, 0x0C, 0x04, 0x04, 0x04. Repeated values are not separate steps. A partial sequence such as 0x0C, 0x0E, 0x04 captures nothing and leaves the current selection in place.
- R3: While a non-burst address is selected, control 0x06 puts the low nibble of the addressed register on statusOut[7:4], and control 0x04 puts the high nibble there. statusOut[3:0] reads 0 in both cases.
- R4: The control step 0x05 to 0x07 writes the data byte into the addressed register. The bank is chosen by address bits [4:3]: 01 is the task bank (0x08) and 10 is the control bank (0x10). Bits [2:0] give the index.
- R5: An address with bank bits 00 or 11 selects no register: writes change nothing and nibble reads return 0.
- R6: Address 0x20 deselects the adapter. While deselected, statusOut stays 0x00 and write strobes are ignored, until another address is captured.
- R7: Task-bank index 0 is a 16-byte FIFO. Writes push in order, pushes to a full FIFO are dropped, and a nibble read shows the oldest byte without removing it.
- R8: An address with bits [7:6] = 11 arms a burst. Each step to control 0xA6 or 0xA4 loads the next byte onto dataOut, taken from the FIFO in order. dataOe is high while armed and control bit 5 is set.
- R9: A step to control 0xAC ends the burst and releases dataOe. A following 0xA4 presents nothing and removes nothing from the FIFO.
- R10: A burst step on an empty FIFO presents 0x00 and leaves the FIFO empty.
- R11: A burst on any register other than the data port presents that register's value on every step and does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostData | input | 8 | Data byte from the host |
| hostCtrl | input | 8 | Control value written by the host |
| statusOut | output | 8 | Status byte to the host, nibble on [7:4] |
| dataOut | output | 8 | Byte driven back during burst reads |
| dataOe | output | 1 | Output enable for dataOut |

## Verification
The assertions check on every cycle that the status byte is quiet whenever nibble display is not allowed, and that the FIFO count never exceeds its depth or drops below zero when a pop meets an empty FIFO. They also check that write and pop strobes never coincide, that dataOe never rises without the host-input control bit, and that a step to the terminate code releases the bus. Only the bench scenarios can show the rest: the order in which bytes leave the FIFO, that a partial address waveform is rejected, that writes while deselected or to an unmapped bank really vanish, and that a terminated burst leaves the next FIFO byte in place.

// File: rtl/ppide_pkg.sv
package ppide_pkg;
  localparam int REG_IDX_W = 3;

  localparam logic [7:0] CTRL_IDLE   = 8'h04;
  localparam logic [7:0] CTRL_NIB_LO = 8'h06;
  localparam logic [7:0] CTRL_NIB_HI = 8'h04;
  localparam logic [7:0] CTRL_SEQ_A  = 8'h0C;
  localparam logic [7:0] CTRL_SEQ_B  = 8'h0E;
  localparam logic [7:0] CTRL_WR_ARM = 8'h05;
  localparam logic [7:0] CTRL_WR_GO  = 8'h07;
  localparam logic [7:0] CTRL_BST_A  = 8'hA6;
  localparam logic [7:0] CTRL_BST_B  = 8'hA4;
  localparam logic [7:0] CTRL_BST_END = 8'hAC;
  localparam logic [7:0] ADDR_RELEASE = 8'h20;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_TASK = 2'd1,
    BANK_CTL  = 2'd2
  } bank_e;

  typedef struct packed {
    logic                 wrStrobe;
    logic                 popStrobe;
    logic                 showNibble;
    bank_e                bank;
    logic [REG_IDX_W-1:0] idx;
  } ctlStrobes_t;

  function automatic bank_e decodeBank(input logic [1:0] sel);
    case (sel)
      2'b01:   return BANK_TASK;
      2'b10:   return BANK_CTL;
      default: return BANK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ppide_ctrl.sv
module ppide_ctrl
  import ppide_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  hostCtrl,
  input  logic [7:0]  hostData,
  output ctlStrobes_t strb,
  output logic [7:0]  ctrlNow,
  output logic [7:0]  dataNow,
  output logic        busDrive
);
  logic [7:0] ctrlPipe [SYNC_STAGES];
  logic [7:0] dataPipe [SYNC_STAGES];
  logic [7:0] ctrlPrev;
  logic       stepped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) begin
        ctrlPipe[i] <= CTRL_IDLE;
        dataPipe[i] <= 8'h00;
      end
      ctrlPrev <= CTRL_IDLE;
    end else begin
      ctrlPipe[0] <= hostCtrl;
      dataPipe[0] <= hostData;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        ctrlPipe[i] <= ctrlPipe[i-1];
        dataPipe[i] <= dataPipe[i-1];
      end
      ctrlPrev <= ctrlNow;
    end
  end

  assign ctrlNow = ctrlPipe[SYNC_STAGES-1];
  assign dataNow = dataPipe[SYNC_STAGES-1];
  assign stepped = (ctrlNow != ctrlPrev);

  // Address waveform matcher: only value changes count as steps
  logic [1:0] seqIdx, seqNext;
  logic       latchHit;

  always_comb begin
    seqNext  = seqIdx;
    latchHit = 1'b0;
    if (stepped) begin
      if (seqIdx == 2'd2 && ctrlNow == CTRL_SEQ_A)      seqNext = 2'd3;
      else if (ctrlNow == CTRL_SEQ_A)                   seqNext = 2'd1;
      else if (seqIdx == 2'd1 && ctrlNow == CTRL_SEQ_B) seqNext = 2'd2;
      else if (seqIdx == 2'd3 && ctrlNow == CTRL_IDLE) begin
        latchHit = 1'b1;
        seqNext  = 2'd0;
      end else                                          seqNext = 2'd0;
    end
  end

  logic                 selected, burstMode, burstArmed;
  bank_e                bankQ;
  logic [REG_IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqIdx     <= 2'd0;
      selected   <= 1'b0;
      burstMode  <= 1'b0;
      burstArmed <= 1'b0;
      bankQ      <= BANK_NONE;
      idxQ       <= '0;
    end else begin
      seqIdx <= seqNext;
      if (latchHit) begin
        selected   <= (dataNow != ADDR_RELEASE);
        burstMode  <= (dataNow != ADDR_RELEASE) && (dataNow[7:6] == 2'b11);
        burstArmed <= (dataNow != ADDR_RELEASE) && (dataNow[7:6] == 2'b11);
        bankQ      <= decodeBank(dataNow[4:3]);
        idxQ       <= dataNow[REG_IDX_W-1:0];
      end else if (stepped && ctrlNow == CTRL_BST_END) begin
        burstArmed <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.wrStrobe   = stepped && ctrlPrev == CTRL_WR_ARM && ctrlNow == CTRL_WR_GO
                      && selected && !burstMode;
    strb.popStrobe  = stepped && burstArmed
                      && (ctrlNow == CTRL_BST_A || ctrlNow == CTRL_BST_B);
    strb.showNibble = selected && !burstMode;
    strb.bank       = bankQ;
    strb.idx        = idxQ;
  end

  assign busDrive = burstArmed && ctrlNow[5];
endmodule

// File: rtl/ppide_dpath.sv
module ppide_dpath
  import ppide_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  input  logic [7:0]  ctrlNow,
  input  logic [7:0]  dataNow,
  output logic [7:0]  statusOut,
  output logic [7:0]  burstByte
);
  localparam int REGS  = 1 << REG_IDX_W;
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [7:0]       taskRegs [REGS];
  logic [7:0]       ctlRegs  [REGS];
  logic [7:0]       fifoMem  [FIFO_DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] fifoCount;

  logic       isData, fifoEmpty, fifoFull, doPush, doPop;
  logic [7:0] readVal;
  logic [3:0] nib;

  assign isData    = (strb.bank == BANK_TASK) && (strb.idx == '0);
  assign fifoEmpty = (fifoCount == '0);
  assign fifoFull  = (fifoCount == CNT_W'(FIFO_DEPTH));
  assign doPush    = strb.wrStrobe && isData && !fifoFull;
  assign doPop     = strb.popStrobe && isData && !fifoEmpty;

  always_comb begin
    case (strb.bank)
      BANK_TASK: readVal = isData ? (fifoEmpty ? 8'h00 : fifoMem[rdPtr])
                                  : taskRegs[strb.idx];
      BANK_CTL:  readVal = ctlRegs[strb.idx];
      default:   readVal = 8'h00;
    endcase
  end

  always_comb begin
    if (ctrlNow == CTRL_NIB_LO)      nib = readVal[3:0];
    else if (ctrlNow == CTRL_NIB_HI) nib = readVal[7:4];
    else                             nib = 4'h0;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REGS; i++) begin
        taskRegs[i] <= 8'h00;
        ctlRegs[i]  <= 8'h00;
      end
      rdPtr     <= '0;
      wrPtr     <= '0;
      fifoCount <= '0;
      statusOut <= 8'h00;
      burstByte <= 8'h00;
    end else begin
      statusOut <= strb.showNibble ? {nib, 4'h0} : 8'h00;
      if (strb.wrStrobe) begin
        if (strb.bank == BANK_TASK && !isData) taskRegs[strb.idx] <= dataNow;
        if (strb.bank == BANK_CTL)             ctlRegs[strb.idx]  <= dataNow;
      end
      if (doPush) begin
        fifoMem[wrPtr] <= dataNow;
        wrPtr          <= bump(wrPtr);
      end
      if (strb.popStrobe) burstByte <= readVal;
      if (doPop) rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
    end
  end
endmodule

// File: rtl/ppide_bridge.sv
module ppide_bridge
  import ppide_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] hostData,
  input  logic [7:0] hostCtrl,
  output logic [7:0] statusOut,
  output logic [7:0] dataOut,
  output logic       dataOe
);
  ctlStrobes_t strb;
  logic [7:0]  ctrlNow, dataNow;

  ppide_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .hostCtrl(hostCtrl), .hostData(hostData),
    .strb(strb), .ctrlNow(ctrlNow), .dataNow(dataNow), .busDrive(dataOe)
  );

  ppide_dpath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlNow(ctrlNow), .dataNow(dataNow),
    .statusOut(statusOut), .burstByte(dataOut)
  );
endmodule

// File: rtl/ppide_bridge_chk.sv
module ppide_bridge_chk
  import ppide_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       statusOut,
  input logic             dataOe,
  input logic [7:0]       ctrlNow,
  input ctlStrobes_t      strb,
  input logic [CNT_W-1:0] fifoCount
);
  // R6: no nibble may appear while display is not allowed
  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.showNibble |=> statusOut == 8'h00);

  // R7: occupancy bounded by depth
  a_r7_fifo_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(FIFO_DEPTH));

  // R10: popping an empty FIFO leaves it empty
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0 && !strb.wrStrobe) |=> fifoCount == '0);

  // R9: a step to the terminate code releases the bus
  a_r9_end_releases: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlNow == CTRL_BST_END && ctrlNow != $past(ctrlNow)) |=> !dataOe);

  // R8: the bus is only driven when control asks for host input
  a_r8_oe_needs_dir: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> ctrlNow[5]);

  // R4: a write and a pop never fall in one cycle
  a_r4_single_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrStrobe, strb.popStrobe}));
endmodule

bind ppide_bridge ppide_bridge_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .statusOut(statusOut), .dataOe(dataOe),
  .ctrlNow(ctrlNow), .strb(strb), .fifoCount(u_dp.fifoCount)
);

// File: tb/sim_ppide_bridge.sv
`timescale 1ns/1ps
module sim_ppide_bridge;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] hostData = 8'h00;
  logic [7:0] hostCtrl = 8'h04;
  logic [7:0] statusOut, dataOut;
  logic       dataOe;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  logic [7:0] mTask [8];
  logic [7:0] mCtl  [8];
  logic [7:0] q [$];

  always #2.5 clk = ~clk;

  ppide_bridge u0 (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostCtrl(hostCtrl),
    .statusOut(statusOut), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic setCtrl(input logic [7:0] v);
    @(negedge clk);
    hostCtrl = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic addrCycle(input logic [7:0] a);
    @(negedge clk);
    hostData = a;
    setCtrl(8'h0C); setCtrl(8'h0E); setCtrl(8'h0E); setCtrl(8'h0C);
    setCtrl(8'h04); setCtrl(8'h04); setCtrl(8'h04);
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    hostData = v;
    setCtrl(8'h05); setCtrl(8'h07); setCtrl(8'h05); setCtrl(8'h04);
  endtask

  task automatic readReg(output logic [7:0] v);
    logic [3:0] lo;
    setCtrl(8'h06);
    lo = statusOut[7:4];
    setCtrl(8'h04);
    v = {statusOut[7:4], lo};
  endtask

  function automatic logic [7:0] expRead(input int b, input int idx);
    if (b == 1) return (idx == 0) ? ((q.size() > 0) ? q[0] : 8'h00) : mTask[idx];
    if (b == 2) return mCtl[idx];
    return 8'h00;
  endfunction

  function automatic logic [7:0] mkAddr(input int b, input int idx);
    return {3'b000, 2'(b), 3'(idx)};
  endfunction

  task automatic modelWrite(input int b, input int idx, input logic [7:0] v);
    if (b == 1 && idx == 0) begin
      if (q.size() < 16) q.push_back(v);
    end else if (b == 1) mTask[idx] = v;
    else if (b == 2)     mCtl[idx] = v;
  endtask

  task automatic burstEnd(input string req);
    setCtrl(8'hAC);
    chk(req, {7'd0, dataOe}, 8'h00);
    setCtrl(8'hA4);
    chk(req, {7'd0, dataOe}, 8'h00);
    setCtrl(8'h04);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] ph;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin mTask[i] = 8'h00; mCtl[i] = 8'h00; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset state
    chk("R1 status", statusOut, 8'h00);
    chk("R1 oe", {7'd0, dataOe}, 8'h00);

    // R3: nibble read of a written task register
    addrCycle(8'h0B);
    writeReg(8'hA5); modelWrite(1, 3, 8'hA5);
    setCtrl(8'h06);
    chk("R3 low nibble", statusOut, 8'h50);
    setCtrl(8'h04);
    chk("R3 high nibble", statusOut, 8'hA0);

    // R4: control bank write
    addrCycle(8'h15);
    writeReg(8'h3C); modelWrite(2, 5, 8'h3C);
    readReg(rv);
    chk("R4 ctl bank", rv, 8'h3C);

    // R2: partial waveform with release byte on data must not capture
    @(negedge clk); hostData = 8'h20;
    setCtrl(8'h0C); setCtrl(8'h0E); setCtrl(8'h04);
    readReg(rv);
    chk("R2 partial ignored", rv, 8'h3C);

    // R5: unmapped banks
    addrCycle(8'h18);
    writeReg(8'h77);
    readReg(rv);
    chk("R5 bank 11", rv, 8'h00);
    addrCycle(8'h02);
    writeReg(8'h66);
    readReg(rv);
    chk("R5 bank 00", rv, 8'h00);
    addrCycle(8'h0B);
    readReg(rv);
    chk("R5 no side effect", rv, 8'hA5);

    // R6: release, write while deselected, reselect
    addrCycle(8'h20);
    setCtrl(8'h06);
    chk("R6 quiet", statusOut, 8'h00);
    setCtrl(8'h04);
    writeReg(8'h99);
    addrCycle(8'h0B);
    readReg(rv);
    chk("R6 write ignored", rv, 8'hA5);

    // Random register traffic against the model (R4 R5 R7)
    for (int n = 0; n < 60; n++) begin
      int b, idx;
      logic [7:0] v;
      b   = int'($urandom % 4);
      idx = ($urandom % 3 == 0) ? 0 : int'($urandom % 8);
      addrCycle(mkAddr(b, idx));
      if ($urandom % 2 == 0) begin
        v = 8'($urandom);
        writeReg(v);
        modelWrite(b, idx, v);
      end
      readReg(rv);
      chk("R4 R7 random readback", rv, expRead(b, idx));
    end

    // R8: drain FIFO in order, then R10 on empty
    addrCycle(8'hC8);
    @(negedge clk); hostData = 8'hFF;
    ph = 8'hA6;
    while (q.size() > 0) begin
      logic [7:0] e;
      e = q.pop_front();
      setCtrl(ph);
      chk("R8 oe", {7'd0, dataOe}, 8'h01);
      chk("R8 burst byte", dataOut, e);
      ph = (ph == 8'hA6) ? 8'hA4 : 8'hA6;
    end
    setCtrl(ph);
    chk("R10 empty byte", dataOut, 8'h00);
    burstEnd("R9 release");

    // R7: overflow drops, order kept, head peek
    addrCycle(8'h08);
    for (int i = 0; i < 18; i++) begin
      writeReg(8'h40 + 8'(i));
      modelWrite(1, 0, 8'h40 + 8'(i));
    end
    readReg(rv);
    chk("R7 head peek", rv, 8'h40);
    addrCycle(8'hC8);
    @(negedge clk); hostData = 8'hFF;
    ph = 8'hA6;
    for (int i = 0; i < 17; i++) begin
      logic [7:0] e;
      e = (q.size() > 0) ? q.pop_front() : 8'h00;
      setCtrl(ph);
      chk("R7 R10 depth order", dataOut, e);
      ph = (ph == 8'hA6) ? 8'hA4 : 8'hA6;
    end
    burstEnd("R9 release");

    // R9: terminate mid-burst keeps the rest
    addrCycle(8'h08);
    writeReg(8'h11); writeReg(8'h22); writeReg(8'h33);
    addrCycle(8'hC8);
    @(negedge clk); hostData = 8'hFF;
    setCtrl(8'hA6);
    chk("R9 first byte", dataOut, 8'h11);
    burstEnd("R9 stop");
    chk("R9 no extra byte", dataOut, 8'h11);
    addrCycle(8'h08);
    readReg(rv);
    chk("R9 fifo untouched", rv, 8'h22);

    // R11: burst on a plain register repeats it
    addrCycle(8'h15);
    writeReg(8'h5E);
    addrCycle(8'hD5);
    @(negedge clk); hostData = 8'hFF;
    setCtrl(8'hA6);
    chk("R11 repeat 1", dataOut, 8'h5E);
    setCtrl(8'hA4);
    chk("R11 repeat 2", dataOut, 8'h5E);
    burstEnd("R11 end");
    addrCycle(8'h15);
    readReg(rv);
    chk("R11 unchanged", rv, 8'h5E);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule